// File: doc/BRIEF.md
# Scaler Bank with Coherent Snapshot

This block counts rising edges on a set of event inputs, one counter per input, next to a free-running timestamp that advances at a fixed fraction of the system clock. Software reads the timestamp word first. That read returns the current timestamp and also freezes a copy of every live counter into a holding register, so the counts that software reads afterwards all belong to the same instant. To get a counting rate, divide the change in a count by the change in the timestamp.

While the copy is taken, counting is held off for a short fixed window. Edges that land inside that window are lost, and the counter keeps the value it had before the window. Writing the timestamp word clears every live counter. The holding registers and the timestamp are left alone.

Top module: `scaler_bank`

## Requirements
- R1: The timestamp is TS_W bits wide (default 32). It is zero after reset, advances by one every CLK_DIV system clocks (default 5, i.e. 20 MHz from 100 MHz) and wraps modulo 2^TS_W.
- R2: Each event input passes through a two-stage synchronizer. Its counter then advances by exactly one for each rising edge of the input.
- R3: A read of word 0 copies every live counter into its holding register in a single clock. The copy happens on the second clock edge after the edge that samples the read, which is one clock after the inhibit starts.
- R4: A read of word 0 holds off counting on the three clock edges that follow the sampling edge. An edge whose count would fall on one of those edges is dropped, not deferred.
- R5: A write to word 0, with any data, clears every live counter to zero. It leaves the holding registers and the timestamp unchanged.
- R6: The counters are CNT_W bits wide (default 32) and wrap modulo 2^CNT_W without saturating.
- R7: Holding registers are zero after reset. They keep their value until the next read of word 0.
- R8: Word addresses map as follows: word 0 is the timestamp, and word 32+k is holding register k for k = 0..31 (0..15 is the first input group, 16..31 the second). Other words read as zero. Read data, zero-extended to 32 bits, appears on rdata_o one clock after the edge that samples rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NUM_CH | Event inputs, may be asynchronous |
| rd_en_i | input | 1 | Read strobe for the word at addr_i |
| wr_en_i | input | 1 | Write strobe; word 0 clears the counters |
| addr_i | input | ADDR_W | Word address |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume three things: the event inputs carry known levels, reset is held for at least one clock, and a read and a write of word 0 never come in the same cycle. Under those conditions the inhibit and snapshot counters step in a fixed order. The stimulus keeps every input pulse high and low for two clocks each, so the synchronizer sees every level. It issues bus accesses one at a time, several clocks apart. The one place where edges and a snapshot read are deliberately placed on exact clock edges is the inhibit-boundary scenario.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_STAMP,
        ACC_HOLD,
        ACC_VOID
    } acc_e;
endpackage

// File: rtl/scaler_timebase.sv
module scaler_timebase #(
    parameter int CLK_DIV = 5,
    parameter int TS_W    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [TS_W-1:0]  ts;
    } tb_s;

    tb_s  tb_d, tb_q;
    logic tick;

    assign tick = (tb_q.div == DIV_W'(CLK_DIV - 1));

    always_comb begin
        tb_d = tb_q;
        if (tick) begin
            tb_d.div = '0;
            tb_d.ts  = tb_q.ts + 1'b1;
        end else begin
            tb_d.div = tb_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign ts_o = tb_q.ts;

    p_ts_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (ts_o == $past(ts_o) + 1'b1));
    p_ts_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ts_o));
    p_div_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tb_q.div) < CLK_DIV);
endmodule

// File: rtl/scaler_edge.sv
module scaler_edge #(
    parameter int NUM_CH      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_i,
    output logic [NUM_CH-1:0] pulse_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_CH-1:0] sync;
        logic [NUM_CH-1:0]                  prev;
    } ed_s;

    ed_s ed_d, ed_q;

    always_comb begin
        ed_d         = ed_q;
        ed_d.sync[0] = ev_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            ed_d.sync[s] = ed_q.sync[s-1];
        end
        ed_d.prev = ed_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign pulse_o = ed_q.sync[SYNC_STAGES-1] & ~ed_q.prev;

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o != '0) |=> ((pulse_o & $past(pulse_o)) == '0));
endmodule

// File: rtl/scaler_cell.sv
module scaler_cell #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             inhibit_i,
    input  logic             clear_i,
    input  logic             snap_i,
    output logic [CNT_W-1:0] hold_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } cell_s;

    cell_s cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clear_i) begin
            cell_d.cnt = '0;
        end else if (pulse_i && !inhibit_i) begin
            cell_d.cnt = cell_q.cnt + 1'b1;
        end
        if (snap_i) begin
            cell_d.hold = cell_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign hold_o = cell_q.hold;

    p_inhibit_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_i && !clear_i) |=> $stable(cell_q.cnt));
    p_snap_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (hold_o == $past(cell_q.cnt)));
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cell_q.cnt == '0));
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cell_q.cnt) && pulse_i && !inhibit_i && !clear_i) |=> (cell_q.cnt == '0));
    p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(hold_o));
endmodule

// File: rtl/scaler_bank.sv
module scaler_bank #(
    parameter int NUM_CH  = 32,
    parameter int CNT_W   = 32,
    parameter int TS_W    = 32,
    parameter int CLK_DIV = 5,
    parameter int INH_CYC = 3,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [31:0]       rdata_o
);
    import scaler_pkg::*;

    localparam int IDX_W = ADDR_W - 1;
    localparam int INH_W = $clog2(INH_CYC + 1);

    typedef struct packed {
        logic [INH_W-1:0]  inh;
        logic [DATA_W-1:0] rdata;
    } ctl_s;

    ctl_s              ctl_d, ctl_q;
    logic [TS_W-1:0]   ts;
    logic [NUM_CH-1:0] pulse;
    logic [CNT_W-1:0]  hold_arr [NUM_CH];
    logic [IDX_W-1:0]  idx;
    logic              stamp_rd, stamp_wr, inhibit, snap;
    acc_e              acc;

    scaler_timebase #(.CLK_DIV(CLK_DIV), .TS_W(TS_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .ts_o  (ts)
    );

    scaler_edge #(.NUM_CH(NUM_CH), .SYNC_STAGES(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_i),
        .pulse_o (pulse)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
        scaler_cell #(.CNT_W(CNT_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .pulse_i   (pulse[c]),
            .inhibit_i (inhibit),
            .clear_i   (stamp_wr),
            .snap_i    (snap),
            .hold_o    (hold_arr[c])
        );
    end

    assign idx      = addr_i[IDX_W-1:0];
    assign stamp_rd = rd_en_i && (addr_i == '0);
    assign stamp_wr = wr_en_i && (addr_i == '0);
    assign inhibit  = (ctl_q.inh != '0);
    assign snap     = (ctl_q.inh == INH_W'(INH_CYC - 1));

    always_comb begin
        if (!rd_en_i)                                   acc = ACC_IDLE;
        else if (addr_i == '0)                          acc = ACC_STAMP;
        else if (addr_i[ADDR_W-1] && int'(idx) < NUM_CH) acc = ACC_HOLD;
        else                                            acc = ACC_VOID;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (stamp_rd)     ctl_d.inh = INH_W'(INH_CYC);
        else if (inhibit) ctl_d.inh = ctl_q.inh - 1'b1;
        case (acc)
            ACC_STAMP: begin
                ctl_d.rdata            = '0;
                ctl_d.rdata[TS_W-1:0]  = ts;
            end
            ACC_HOLD: begin
                ctl_d.rdata            = '0;
                ctl_d.rdata[CNT_W-1:0] = hold_arr[idx];
            end
            ACC_VOID: ctl_d.rdata = '0;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rdata_o = ctl_q.rdata;

    p_inhibit_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_rd |=> inhibit);
    p_snap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> !snap);
    p_stamp_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_rd |=> (rdata_o[TS_W-1:0] == $past(ts)));
    p_void_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_VOID) |=> (rdata_o == '0));
endmodule

// File: tb/sim_scaler_bank.sv
module sim_scaler_bank;
    localparam int NCH = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ev = '0;
    logic           rd_en = 1'b0;
    logic           wr_en = 1'b0;
    logic [5:0]     addr = '0;
    logic [31:0]    rdata;
    int             checks = 0;
    int             errors = 0;

    always #2 clk = ~clk;

    scaler_bank #(.CNT_W(8)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .rd_en_i (rd_en),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .rdata_o (rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d     = rdata;
    endtask

    task automatic clr();
        addr  = '0;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic snapshot();
        logic [31:0] d;
        rd(6'd0, d);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic [NCH-1:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            ev = ev | mask;
            repeat (2) @(negedge clk);
            ev = ev & ~mask;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(6'd0, d);
        check("R1 reset timestamp", d, 32'd0);
        repeat (4) @(negedge clk);
        rd(6'd37, d);
        check("R7 reset hold", d, 32'd0);
    endtask

    task automatic t_rate();
        logic [31:0] a, b;
        rd(6'd0, a);
        repeat (49) @(negedge clk);
        rd(6'd0, b);
        check("R1 rate 50 clocks", b - a, 32'd10);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_count();
        logic [31:0] d;
        clr();
        pulse(32'h0000_0001, 3);
        pulse(32'h8000_0000, 7);
        pulse(32'h0001_0000, 1);
        pulse(32'h0001_0001, 2);
        snapshot();
        rd(6'd32, d); check("R2 ch0 count", d, 32'd5);
        rd(6'd63, d); check("R2 ch31 count", d, 32'd7);
        rd(6'd48, d); check("R8 ch16 second group", d, 32'd3);
        rd(6'd33, d); check("R2 idle ch1", d, 32'd0);
        rd(6'd5, d);  check("R8 unmapped word", d, 32'd0);
    endtask

    task automatic t_keep();
        logic [31:0] d;
        pulse(32'h0000_0001, 2);
        rd(6'd32, d); check("R7 hold unchanged", d, 32'd5);
        snapshot();
        rd(6'd32, d); check("R3 new snapshot", d, 32'd7);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        clr();
        rd(6'd32, d); check("R5 hold survives clear", d, 32'd7);
        snapshot();
        rd(6'd32, d); check("R5 ch0 cleared", d, 32'd0);
        rd(6'd63, d); check("R5 ch31 cleared", d, 32'd0);
        rd(6'd0, d);  check("R5 timestamp kept", {31'd0, d != 32'd0}, 32'd1);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_inhibit();
        logic [31:0] d;
        clr();
        ev[4] = 1'b1;
        repeat (2) @(negedge clk);
        ev[5] = 1'b1;
        addr  = '0;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        ev[4] = 1'b0;
        ev[5] = 1'b0;
        repeat (6) @(negedge clk);
        rd(6'd36, d); check("R4 edge before window counted", d, 32'd1);
        rd(6'd37, d); check("R4 edge inside window dropped", d, 32'd0);
        snapshot();
        rd(6'd37, d); check("R4 dropped not deferred", d, 32'd0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        clr();
        pulse(32'h0000_0080, 260);
        snapshot();
        rd(6'd39, d); check("R6 wrap 260 mod 256", d, 32'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate();
        t_count();
        t_keep();
        t_clear();
        t_inhibit();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule